// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives one device clock from a single parent clock. A small set of plain control pins stands in for its register interface. A one-bit enable register gates the output. A divisor register holds the division field, and a status byte tells software when it is safe to write again. Software writes a divisor, then polls the status byte until the busy bits clear. From that point the output runs at the new ratio.

Two field encodings exist, chosen by the `ext_mode` strap. In normal mode only the low five bits of the divisor field count. A value from 1 to 31 divides by that value, and zero divides by 32. In extended mode all six bits count. With bit 5 clear, the low five bits divide as in normal mode, except that zero now means 64. With bit 5 set, a fixed divide-by-64 stage multiplies the low five bits, and a zero low part again gives 64. A new ratio is never applied in the middle of an output period. It is loaded when the running period ends. The enable gate is retimed on the falling parent edge and only moves while the divided phase is low, so no pulse is ever clipped. The strap is meant to be static; change it only together with a divisor write.

The block has no streaming data path, so no valid/ready handshake applies. All pins are plain control and status, sampled on the rising parent edge.

Top module: `gated_clk_divider`

## Requirements
- R1: In normal mode a divisor field whose low five bits N are 1 to 31 (bit 5 ignored) gives an output period of N parent cycles. The same holds in extended mode with bit 5 clear and N nonzero.
- R2: A low five-bit value of zero with bit 5 clear divides by 32 in normal mode and by 64 in extended mode.
- R3: In extended mode with bit 5 set and low five bits L from 1 to 31, the ratio is 64*L.
- R4: In extended mode with bit 5 set and L equal to zero, the ratio is 64.
- R5: For every ratio R of 2 or more, each output period starts with a high phase of floor(R/2) parent cycles, followed by R-floor(R/2) low cycles.
- R6: A ratio of 1 passes the parent clock through the gate: the output is high while the parent is high and low while it is low.
- R7: Writing 0 to the enable bit holds the output low, and writing 1 lets it run. `en_rd` returns the written enable bit.
- R8: The gate changes state only while the divided phase is low, so the first pulse after enabling is a full high phase of floor(R/2) cycles.
- R9: `status_rd` bits 4 and 3 read 1 from the edge that captures a divisor write until the edge that loads the new ratio. They read 0 otherwise, and the other status bits always read 0.
- R10: A new ratio is loaded only at the end of the running output period. The busy bits therefore clear no more than one old period after the write.
- R11: After reset the enable bit and the divisor field read 0, the status reads 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode | input | 1 | Strap: 1 selects the six-bit extended field encoding |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 1 | Enable bit value to write |
| div_wr | input | 1 | Write strobe for the divisor register |
| div_wdata | input | 6 | Divisor field value to write |
| en_rd | output | 1 | Read-back of the enable bit |
| div_rd | output | 6 | Read-back of the divisor field |
| status_rd | output | 8 | Status byte; bits 4 and 3 are busy |
| clk_out | output | 1 | Divided and gated device clock |

## Verification
Register writes are driven on the falling parent edge and take effect at the next rising edge. The busy bits are therefore checked on the falling edge after the write, and then polled once per cycle until they clear. That wait is bounded by one old output period plus a cycle. The output is sampled 2 ns after each rising edge, where the divided level settles one register after the counter. This gives one sample per parent cycle, and the period and high time are counted from one rising sample to the next. Enable changes reach the output only after the falling-edge gate register and the next low phase, so the bench waits two full periods before it samples for a held-low output. The pass-through ratio is checked in both halves of the parent cycle.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  localparam int FIELD_W   = 6;
  localparam int LOW_W     = FIELD_W - 1;
  localparam int PRE_SHIFT = 6;
  localparam int RATIO_W   = LOW_W + PRE_SHIFT;
  localparam int STAT_W    = 8;
  localparam int BUSY_LO   = 3;
  localparam int BUSY_HI   = 4;

  // Effective parent-cycles-per-output-period for a field value.
  function automatic logic [RATIO_W-1:0] field_ratio(input logic [FIELD_W-1:0] f,
                                                     input logic ext);
    logic [LOW_W-1:0] lo;
    logic [RATIO_W-1:0] r;
    lo = f[LOW_W-1:0];
    if (!ext) begin
      r = (lo == '0) ? (RATIO_W'(1) << LOW_W) : RATIO_W'(lo);
    end else if (f[FIELD_W-1]) begin
      r = (lo == '0) ? (RATIO_W'(1) << PRE_SHIFT) : (RATIO_W'(lo) << PRE_SHIFT);
    end else begin
      r = (lo == '0) ? (RATIO_W'(1) << FIELD_W) : RATIO_W'(lo);
    end
    return r;
  endfunction
endpackage

// File: rtl/gcd_ctrl_regs.sv
module gcd_ctrl_regs
  import gcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               en_wdata,
  input  logic               div_wr,
  input  logic [FIELD_W-1:0] div_wdata,
  input  logic               load_ack,
  output logic               en_q,
  output logic [FIELD_W-1:0] field_q,
  output logic               pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      field_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata;
      if (div_wr) begin
        field_q <= div_wdata;
        pend_q  <= 1'b1;
      end else if (load_ack) begin
        pend_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gcd_div_core.sv
module gcd_div_core
  import gcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode,
  input  logic [FIELD_W-1:0] field_in,
  input  logic               pend,
  output logic               load_ack,
  output logic               hi_q,
  output logic               pass_q,
  output logic               at_end,
  output logic [FIELD_W-1:0] cur_field
);
  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] cur_ratio;
  logic [RATIO_W-1:0] nxt_ratio;
  logic [FIELD_W-1:0] nxt_field;
  logic [RATIO_W-1:0] cnt_nxt;
  logic [RATIO_W-1:0] half;

  assign cur_ratio = field_ratio(cur_field, ext_mode);
  assign at_end    = (cnt_q >= cur_ratio - RATIO_W'(1));
  assign load_ack  = at_end && pend;
  assign nxt_field = load_ack ? field_in : cur_field;
  assign nxt_ratio = field_ratio(nxt_field, ext_mode);

  always_comb begin
    if (at_end) begin
      cnt_nxt = '0;
      half    = nxt_ratio >> 1;
    end else begin
      cnt_nxt = cnt_q + RATIO_W'(1);
      half    = cur_ratio >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hi_q      <= 1'b0;
      pass_q    <= 1'b0;
      cur_field <= '0;
    end else begin
      cnt_q     <= cnt_nxt;
      hi_q      <= (cnt_nxt < half);
      cur_field <= nxt_field;
      if (at_end) pass_q <= (nxt_ratio == RATIO_W'(1));
    end
  end
endmodule

// File: rtl/gcd_gate.sv
module gcd_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hi,
  input  logic pass,
  output logic gate_q,
  output logic clk_out
);
  logic may_move;

  // In pass-through the parent is low at its falling edge; otherwise wait for a low phase.
  assign may_move = pass || !hi;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)        gate_q <= 1'b0;
    else if (may_move) gate_q <= en;
  end

  assign clk_out = gate_q & (pass ? clk : hi);
endmodule

// File: rtl/gated_clk_divider.sv
module gated_clk_divider
  import gcd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_mode,
  input  logic               en_wr,
  input  logic               en_wdata,
  input  logic               div_wr,
  input  logic [FIELD_W-1:0] div_wdata,
  output logic               en_rd,
  output logic [FIELD_W-1:0] div_rd,
  output logic [STAT_W-1:0]  status_rd,
  output logic               clk_out
);
  logic               en_q;
  logic [FIELD_W-1:0] field_q;
  logic               pend_q;
  logic               load_ack;
  logic               hi_q;
  logic               pass_q;
  logic               at_end;
  logic [FIELD_W-1:0] cur_field;
  logic               gate_q;

  gcd_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .load_ack(load_ack),
    .en_q(en_q), .field_q(field_q), .pend_q(pend_q)
  );

  gcd_div_core u_core (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .field_in(field_q),
    .pend(pend_q), .load_ack(load_ack), .hi_q(hi_q), .pass_q(pass_q),
    .at_end(at_end), .cur_field(cur_field)
  );

  gcd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .en(en_q), .hi(hi_q), .pass(pass_q),
    .gate_q(gate_q), .clk_out(clk_out)
  );

  always_comb begin
    status_rd = '0;
    for (int b = BUSY_LO; b <= BUSY_HI; b++) status_rd[b] = pend_q;
  end

  assign en_rd  = en_q;
  assign div_rd = field_q;
endmodule

// File: rtl/gcd_checker.sv
module gcd_checker
  import gcd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               div_wr,
  input logic [STAT_W-1:0]  status_rd,
  input logic [FIELD_W-1:0] div_rd,
  input logic [FIELD_W-1:0] cur_field,
  input logic               at_end,
  input logic               hi_q,
  input logic               pass_q,
  input logic               gate_q
);
  a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> (status_rd == STAT_W'(8'h18)));

  a_r9_idle_matches_field: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd == '0) |-> (cur_field == div_rd));

  a_r10_load_at_period_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_field) |-> $past(at_end));

  a_r10_busy_clears_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_rd[BUSY_LO]) |-> $past(at_end));

  a_r8_gate_falls_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_q && $fell(gate_q)) |-> !hi_q);

  a_r8_gate_rises_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_q && $rose(gate_q)) |-> !hi_q);
endmodule

bind gated_clk_divider gcd_checker u_gcd_checker (
  .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .status_rd(status_rd),
  .div_rd(div_rd), .cur_field(cur_field), .at_end(at_end), .hi_q(hi_q),
  .pass_q(pass_q), .gate_q(gate_q)
);

// File: tb/gated_clk_divider_bench.sv
`timescale 1ns/1ps
module gated_clk_divider_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_mode = 1'b0;
  logic       en_wr = 1'b0;
  logic       en_wdata = 1'b0;
  logic       div_wr = 1'b0;
  logic [5:0] div_wdata = '0;
  logic       en_rd;
  logic [5:0] div_rd;
  logic [7:0] status_rd;
  logic       clk_out;

  int checks = 0;
  int errors = 0;
  int cur_r = 32;
  logic [5:0] cur_f = '0;

  always #5 clk = ~clk;

  gated_clk_divider u_gated_clk_divider (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .en_wr(en_wr), .en_wdata(en_wdata),
    .div_wr(div_wr), .div_wdata(div_wdata), .en_rd(en_rd), .div_rd(div_rd),
    .status_rd(status_rd), .clk_out(clk_out)
  );

  function automatic int exp_ratio(input logic [5:0] f, input logic ext);
    int lo;
    lo = int'(f[4:0]);
    if (!ext) return (lo == 0) ? 32 : lo;
    if (f[5]) return (lo == 0) ? 64 : 64 * lo;
    return (lo == 0) ? 64 : lo;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_en(input logic b);
    @(negedge clk); en_wr = 1'b1; en_wdata = b;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic wr_div(input logic [5:0] f, input logic ext);
    int n;
    int bound;
    bound = exp_ratio(cur_f, 1'b0);
    if (exp_ratio(cur_f, 1'b1) > bound) bound = exp_ratio(cur_f, 1'b1);
    @(negedge clk); ext_mode = ext; div_wr = 1'b1; div_wdata = f;
    @(negedge clk); div_wr = 1'b0;
    check(status_rd == 8'h18, "R9 busy set", int'(status_rd), 8'h18);
    check(div_rd == f, "R9 readback", int'(div_rd), int'(f));
    n = 0;
    while (status_rd != 8'h00 && n < 5000) begin
      @(negedge clk); n++;
    end
    check(n <= bound + 1, "R10 busy clears within old period", n, bound + 1);
    cur_f = f;
    cur_r = exp_ratio(f, ext);
  endtask

  task automatic measure(input int expr, input string req);
    logic prev, s;
    int high, total, guard;
    if (expr == 1) begin
      for (int k = 0; k < 4; k++) begin
        @(posedge clk); #2;
        check(clk_out == 1'b1, {req, " pass high"}, int'(clk_out), 1);
        #5;
        check(clk_out == 1'b0, {req, " pass low"}, int'(clk_out), 0);
      end
      return;
    end
    @(posedge clk); #2; prev = clk_out;
    guard = 0;
    forever begin
      @(posedge clk); #2; s = clk_out; guard++;
      if (s && !prev) break;
      prev = s;
      if (guard > 2 * expr + 8) break;
    end
    high = 1; total = 1; prev = 1'b1; guard = 0;
    forever begin
      @(posedge clk); #2; s = clk_out; guard++;
      if (s && !prev) break;
      total++; high += int'(s); prev = s;
      if (guard > 2 * expr + 8) break;
    end
    check(total == expr, {req, " period"}, total, expr);
    check(high == expr / 2, "R5 high phase", high, expr / 2);
  endtask

  task automatic run_case(input logic [5:0] f, input logic ext, input string req);
    wr_div(f, ext);
    measure(exp_ratio(f, ext), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int zeros;
    void'($urandom(32'd4242));
    #23 rst_n = 1'b1;
    @(negedge clk);
    check(en_rd == 1'b0, "R11 enable reset", int'(en_rd), 0);
    check(div_rd == 6'd0, "R11 divisor reset", int'(div_rd), 0);
    check(status_rd == 8'd0, "R11 status reset", int'(status_rd), 0);
    zeros = 0;
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); #2; zeros += int'(clk_out == 1'b0);
    end
    check(zeros == 80, "R11 output low", zeros, 80);

    wr_div(6'd10, 1'b0);
    wr_en(1'b1);
    check(en_rd == 1'b1, "R7 enable readback", int'(en_rd), 1);
    measure(10, "R8 first pulse full");

    run_case(6'd2, 1'b0, "R1 ratio2");
    run_case(6'd7, 1'b0, "R1 odd7");
    run_case(6'd31, 1'b0, "R1 ratio31");
    run_case(6'h25, 1'b0, "R1 bit5 ignored");
    run_case(6'd0, 1'b0, "R2 normal zero");
    run_case(6'd1, 1'b0, "R6 passthrough");
    run_case(6'd0, 1'b1, "R2 ext zero");
    run_case(6'd5, 1'b1, "R1 ext low5");
    run_case(6'h20, 1'b1, "R4 prescale zero");
    run_case(6'h21, 1'b1, "R3 prescale x1");
    run_case(6'h23, 1'b1, "R3 prescale x3");

    run_case(6'd9, 1'b0, "R7 setup");
    wr_en(1'b0);
    check(en_rd == 1'b0, "R7 disable readback", int'(en_rd), 0);
    repeat (2 * cur_r) @(posedge clk);
    zeros = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2; zeros += int'(clk_out == 1'b0);
      #5; zeros += int'(clk_out == 1'b0);
    end
    check(zeros == 80, "R7 held low", zeros, 80);
    wr_en(1'b1);
    measure(9, "R8 reenable full pulse");

    for (int it = 0; it < 12; it++) begin
      logic [5:0] f;
      logic e;
      f = 6'($urandom);
      e = 1'($urandom);
      if (e && f[5]) f[4] = 1'b0;
      run_case(f, e, f[5] && e ? "R3 random" : "R1 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule